// File: doc/BRIEF.md
# Operand-Capturing Wakeup and Select Queue

This block holds instructions that wait for their two source operands. Each instruction comes in through a dispatch stream with a slot number, an opcode, a destination tag and, for each source, a tag, a ready flag and a value. Sources that are already known arrive ready with their value. Sources that are still being computed arrive not ready. Such a source waits until a result bus carries its tag, and then takes the value from that bus. Each slot compares its two source tags against every result bus in the same cycle. The operand values are kept inside the slots. When an instruction issues, it carries its opcode, both values and its destination tag straight to the execution side, and no register read follows select.

Slots whose two sources are ready and that have not yet issued bid for the single issue port. A fixed-priority arbiter grants the lowest-numbered bidder. The grant goes out as a valid/ready offer. An offer that is not accepted stays frozen, so a lower slot that wakes up later cannot replace it. An issued slot stays occupied and does not bid again. It is released only by an explicit free request. The consumer of the issued destination tag drives the result back on a result bus.

Back-pressure rules:
- Dispatch is accepted in a cycle where `disp_valid` and `disp_ready` are both high.
- `disp_ready` is low when the named slot is occupied.
- Issue is taken in a cycle where `iss_valid` and `iss_ready` are both high.
- While `iss_valid` is high and `iss_ready` is low, the slot and payload on the issue port do not change.

Top module: `dc_issue_queue`

## Requirements
- R1: After reset the queue is empty. `q_empty` is 1, `q_full` is 0, `iss_valid` is 0 and `disp_ready` is 1.
- R2: A dispatch is accepted only into an unoccupied slot (`disp_ready` = 0 otherwise). A refused dispatch leaves the occupant's opcode, tags and values unchanged.
- R3: A source marked ready at dispatch keeps the dispatched value, and that value is what issues.
- R4: A waiting source whose tag appears on a valid result bus captures that bus's value and becomes ready. The slot can be offered on `iss_valid` in the cycle after the broadcast.
- R5: A source that is already ready ignores a later broadcast of its tag, and its value is unchanged.
- R6: A slot bids only when both sources are ready, it is occupied and it has not issued. Each dispatched instruction issues exactly once.
- R7: When no offer is pending, the lowest-numbered bidding slot is granted.
- R8: While `iss_valid` is 1 and `iss_ready` is 0, the next cycle still shows `iss_valid` with the same `iss_slot`, `iss_op`, `iss_dst`, `iss_lval` and `iss_rval`.
- R9: If a dispatched not-ready source matches a result bus in the dispatch cycle, the bus value is captured and the source is ready.
- R10: If several result buses carry the same waiting tag in one cycle, the value of the lowest-numbered bus is taken.
- R11: `free_valid` releases slot `free_slot`. `q_full` is 1 exactly when every slot is occupied, and `q_empty` is 1 exactly when none is.
- R12: The issue port carries the granted slot's number, opcode and destination tag, with the left value on `iss_lval` and the right value on `iss_rval`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch offer |
| disp_ready | output | 1 | Named slot is free; dispatch accepted when both high |
| disp_slot | input | IDX_W | Target slot of the dispatch |
| disp_op | input | OP_W | Opcode |
| disp_dst | input | TAG_W | Destination tag |
| disp_ltag | input | TAG_W | Left source tag |
| disp_lrdy | input | 1 | Left source value is valid |
| disp_lval | input | DATA_W | Left source value |
| disp_rtag | input | TAG_W | Right source tag |
| disp_rrdy | input | 1 | Right source value is valid |
| disp_rval | input | DATA_W | Right source value |
| bc_valid | input | NUM_BUS | Per-bus result valid |
| bc_tag | input | NUM_BUS*TAG_W | Result tags, bus b at bits b*TAG_W |
| bc_data | input | NUM_BUS*DATA_W | Result values, bus b at bits b*DATA_W |
| iss_valid | output | 1 | Issue offer |
| iss_ready | input | 1 | Execution side accepts the offer |
| iss_slot | output | IDX_W | Slot being issued |
| iss_op | output | OP_W | Issued opcode |
| iss_dst | output | TAG_W | Issued destination tag |
| iss_lval | output | DATA_W | Issued left value |
| iss_rval | output | DATA_W | Issued right value |
| free_valid | input | 1 | Release request |
| free_slot | input | IDX_W | Slot to release |
| q_full | output | 1 | All slots occupied |
| q_empty | output | 1 | No slot occupied |

## Verification
Two functions can fall on the same slot in the same cycle: dispatch writing a source, and a result bus delivering that source's tag. The bench provokes this by driving a broadcast in the very cycle of a dispatch whose source is marked not ready. It then checks that the issued value is the bus value. A second overlap is a wakeup of two slots together while the issue port is stalled. The bench judges the winner from `iss_slot` and then checks that the frozen offer is kept until it is accepted. Randomly delayed result broadcasts over a dependency chain are checked against a bench model that sums operands along the chain.

// File: rtl/iq_pkg.sv
package iq_pkg;
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/iq_operand.sv
// One source operand: tag store, per-bus comparators, value capture.
module iq_operand #(
  parameter int TAG_W   = 6,
  parameter int DATA_W  = 16,
  parameter int NUM_BUS = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [TAG_W-1:0]          load_tag,
  input  logic                      load_rdy,
  input  logic [DATA_W-1:0]         load_val,
  input  logic [NUM_BUS-1:0]        bc_valid,
  input  logic [NUM_BUS*TAG_W-1:0]  bc_tag,
  input  logic [NUM_BUS*DATA_W-1:0] bc_data,
  output logic                      rdy,
  output logic [DATA_W-1:0]         val
);
  logic [TAG_W-1:0]   tag_q;
  logic [TAG_W-1:0]   cmp_tag;
  logic [NUM_BUS-1:0] match;
  logic               hit;
  logic [DATA_W-1:0]  hit_val;
  logic               rdy_q;
  logic [DATA_W-1:0]  val_q;

  // during dispatch the incoming tag is compared so a same-cycle result is not lost
  assign cmp_tag = load ? load_tag : tag_q;

  genvar b;
  generate
    for (b = 0; b < NUM_BUS; b++) begin : g_cmp
      assign match[b] = bc_valid[b] && (bc_tag[b*TAG_W +: TAG_W] == cmp_tag);
    end
  endgenerate

  // lowest-numbered matching bus wins
  always_comb begin
    hit     = 1'b0;
    hit_val = '0;
    for (int i = NUM_BUS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_val = bc_data[i*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q <= '0;
      rdy_q <= 1'b0;
      val_q <= '0;
    end else if (load) begin
      tag_q <= load_tag;
      if (load_rdy) begin
        rdy_q <= 1'b1;
        val_q <= load_val;
      end else if (hit) begin
        rdy_q <= 1'b1;
        val_q <= hit_val;
      end else begin
        rdy_q <= 1'b0;
      end
    end else if (!rdy_q && hit) begin
      rdy_q <= 1'b1;
      val_q <= hit_val;
    end
  end

  assign rdy = rdy_q;
  assign val = val_q;
endmodule

// File: rtl/iq_entry.sv
// One queue slot: occupancy, issued flag, opcode/destination and two operands.
module iq_entry #(
  parameter int TAG_W   = 6,
  parameter int DATA_W  = 16,
  parameter int OP_W    = 4,
  parameter int NUM_BUS = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [OP_W-1:0]           wr_op,
  input  logic [TAG_W-1:0]          wr_dst,
  input  logic [TAG_W-1:0]          wr_ltag,
  input  logic                      wr_lrdy,
  input  logic [DATA_W-1:0]         wr_lval,
  input  logic [TAG_W-1:0]          wr_rtag,
  input  logic                      wr_rrdy,
  input  logic [DATA_W-1:0]         wr_rval,
  input  logic [NUM_BUS-1:0]        bc_valid,
  input  logic [NUM_BUS*TAG_W-1:0]  bc_tag,
  input  logic [NUM_BUS*DATA_W-1:0] bc_data,
  input  logic                      fire,
  input  logic                      free,
  output logic                      busy,
  output logic                      bid,
  output logic [OP_W-1:0]           op,
  output logic [TAG_W-1:0]          dst,
  output logic [DATA_W-1:0]         lval,
  output logic [DATA_W-1:0]         rval
);
  logic            busy_q;
  logic            issued_q;
  logic [OP_W-1:0] op_q;
  logic [TAG_W-1:0] dst_q;
  logic            lrdy;
  logic            rrdy;

  iq_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W), .NUM_BUS(NUM_BUS)) u_left (
    .clk(clk), .rst_n(rst_n), .load(wr_en), .load_tag(wr_ltag), .load_rdy(wr_lrdy),
    .load_val(wr_lval), .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .rdy(lrdy), .val(lval)
  );

  iq_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W), .NUM_BUS(NUM_BUS)) u_right (
    .clk(clk), .rst_n(rst_n), .load(wr_en), .load_tag(wr_rtag), .load_rdy(wr_rrdy),
    .load_val(wr_rval), .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .rdy(rrdy), .val(rval)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      issued_q <= 1'b0;
      op_q     <= '0;
      dst_q    <= '0;
    end else if (wr_en) begin
      busy_q   <= 1'b1;
      issued_q <= 1'b0;
      op_q     <= wr_op;
      dst_q    <= wr_dst;
    end else begin
      if (fire) issued_q <= 1'b1;
      if (free) busy_q   <= 1'b0;
    end
  end

  assign busy = busy_q;
  assign bid  = busy_q && !issued_q && lrdy && rrdy;
  assign op   = op_q;
  assign dst  = dst_q;
endmodule

// File: rtl/iq_select.sv
// Fixed-priority 1-of-N grant: slot 0 highest.
module iq_select #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     gnt,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  logic [N:0] seen;

  assign seen[0] = 1'b0;
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_chain
      assign gnt[i]    = req[i] && !seen[i];
      assign seen[i+1] = seen[i] || req[i];
    end
  endgenerate

  assign any = seen[N];

  always_comb begin
    idx = '0;
    for (int k = 0; k < N; k++) begin
      if (gnt[k]) idx = IDX_W'(k);
    end
  end
endmodule

// File: rtl/dc_issue_queue.sv
module dc_issue_queue #(
  parameter int NUM_ENTRIES = 8,
  parameter int NUM_BUS     = 2,
  parameter int TAG_W       = 6,
  parameter int DATA_W      = 16,
  parameter int OP_W        = 4,
  localparam int IDX_W      = iq_pkg::idx_width(NUM_ENTRIES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      disp_valid,
  output logic                      disp_ready,
  input  logic [IDX_W-1:0]          disp_slot,
  input  logic [OP_W-1:0]           disp_op,
  input  logic [TAG_W-1:0]          disp_dst,
  input  logic [TAG_W-1:0]          disp_ltag,
  input  logic                      disp_lrdy,
  input  logic [DATA_W-1:0]         disp_lval,
  input  logic [TAG_W-1:0]          disp_rtag,
  input  logic                      disp_rrdy,
  input  logic [DATA_W-1:0]         disp_rval,
  input  logic [NUM_BUS-1:0]        bc_valid,
  input  logic [NUM_BUS*TAG_W-1:0]  bc_tag,
  input  logic [NUM_BUS*DATA_W-1:0] bc_data,
  output logic                      iss_valid,
  input  logic                      iss_ready,
  output logic [IDX_W-1:0]          iss_slot,
  output logic [OP_W-1:0]           iss_op,
  output logic [TAG_W-1:0]          iss_dst,
  output logic [DATA_W-1:0]         iss_lval,
  output logic [DATA_W-1:0]         iss_rval,
  input  logic                      free_valid,
  input  logic [IDX_W-1:0]          free_slot,
  output logic                      q_full,
  output logic                      q_empty
);
  logic [NUM_ENTRIES-1:0] busy;
  logic [NUM_ENTRIES-1:0] bid;
  logic [NUM_ENTRIES-1:0] wr_en;
  logic [NUM_ENTRIES-1:0] free_en;
  logic [NUM_ENTRIES-1:0] fire_en;
  logic [NUM_ENTRIES-1:0] sel_gnt;
  logic [NUM_ENTRIES-1:0] eff_gnt;
  logic                   sel_any;
  logic [IDX_W-1:0]       sel_idx;
  logic                   lock_q;
  logic [IDX_W-1:0]       lock_slot_q;
  logic                   slot_busy;
  logic                   fire;

  logic [OP_W-1:0]   e_op   [NUM_ENTRIES];
  logic [TAG_W-1:0]  e_dst  [NUM_ENTRIES];
  logic [DATA_W-1:0] e_lval [NUM_ENTRIES];
  logic [DATA_W-1:0] e_rval [NUM_ENTRIES];

  // ---------------- dispatch side ----------------
  always_comb begin
    slot_busy = 1'b1;
    for (int k = 0; k < NUM_ENTRIES; k++) begin
      if (disp_slot == IDX_W'(k)) slot_busy = busy[k];
    end
  end

  assign disp_ready = !slot_busy;

  genvar g;
  generate
    for (g = 0; g < NUM_ENTRIES; g++) begin : g_slot
      assign wr_en[g]   = disp_valid && disp_ready && (disp_slot == IDX_W'(g));
      assign free_en[g] = free_valid && (free_slot == IDX_W'(g));
      assign fire_en[g] = fire && eff_gnt[g];

      iq_entry #(.TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W), .NUM_BUS(NUM_BUS)) u_entry (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en[g]), .wr_op(disp_op), .wr_dst(disp_dst),
        .wr_ltag(disp_ltag), .wr_lrdy(disp_lrdy), .wr_lval(disp_lval),
        .wr_rtag(disp_rtag), .wr_rrdy(disp_rrdy), .wr_rval(disp_rval),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
        .fire(fire_en[g]), .free(free_en[g]),
        .busy(busy[g]), .bid(bid[g]),
        .op(e_op[g]), .dst(e_dst[g]), .lval(e_lval[g]), .rval(e_rval[g])
      );
    end
  endgenerate

  // ---------------- select side ----------------
  iq_select #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_select (
    .req(bid), .gnt(sel_gnt), .any(sel_any), .idx(sel_idx)
  );

  // a stalled offer is frozen on its slot until accepted
  always_comb begin
    if (lock_q) begin
      eff_gnt = '0;
      for (int k = 0; k < NUM_ENTRIES; k++) begin
        if (lock_slot_q == IDX_W'(k)) eff_gnt[k] = bid[k];
      end
    end else begin
      eff_gnt = sel_gnt;
    end
  end

  assign iss_valid = |eff_gnt;
  assign iss_slot  = lock_q ? lock_slot_q : sel_idx;
  assign fire      = iss_valid && iss_ready;

  always_comb begin
    iss_op   = '0;
    iss_dst  = '0;
    iss_lval = '0;
    iss_rval = '0;
    for (int k = 0; k < NUM_ENTRIES; k++) begin
      iss_op   = iss_op   | ({OP_W{eff_gnt[k]}}   & e_op[k]);
      iss_dst  = iss_dst  | ({TAG_W{eff_gnt[k]}}  & e_dst[k]);
      iss_lval = iss_lval | ({DATA_W{eff_gnt[k]}} & e_lval[k]);
      iss_rval = iss_rval | ({DATA_W{eff_gnt[k]}} & e_rval[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q      <= 1'b0;
      lock_slot_q <= '0;
    end else if (iss_valid && !iss_ready) begin
      lock_q      <= 1'b1;
      lock_slot_q <= iss_slot;
    end else begin
      lock_q      <= 1'b0;
    end
  end

  assign q_full  = &busy;
  assign q_empty = ~|busy;

  logic unused_any;
  assign unused_any = sel_any;
endmodule

// File: rtl/dc_issue_queue_chk.sv
module dc_issue_queue_chk #(
  parameter int NUM_ENTRIES = 8,
  parameter int NUM_BUS     = 2,
  parameter int TAG_W       = 6,
  parameter int DATA_W      = 16,
  parameter int OP_W        = 4,
  localparam int IDX_W      = iq_pkg::idx_width(NUM_ENTRIES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              disp_valid,
  input logic              disp_ready,
  input logic              iss_valid,
  input logic              iss_ready,
  input logic [IDX_W-1:0]  iss_slot,
  input logic [OP_W-1:0]   iss_op,
  input logic [TAG_W-1:0]  iss_dst,
  input logic [DATA_W-1:0] iss_lval,
  input logic [DATA_W-1:0] iss_rval,
  input logic              free_valid,
  input logic [IDX_W-1:0]  free_slot,
  input logic              q_full,
  input logic              q_empty
);
  a_r8_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready && !(free_valid && free_slot == iss_slot))
      |=> (iss_valid && $stable(iss_slot) && $stable(iss_op) && $stable(iss_dst)
           && $stable(iss_lval) && $stable(iss_rval)));

  a_r6_issue_once: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |=> !(iss_valid && iss_slot == $past(iss_slot)));

  a_r2_refuse_occupied: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |-> !q_empty);

  a_r11_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !disp_ready);

  a_r11_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
    q_empty |-> !iss_valid);
endmodule

bind dc_issue_queue dc_issue_queue_chk #(
  .NUM_ENTRIES(NUM_ENTRIES), .NUM_BUS(NUM_BUS), .TAG_W(TAG_W),
  .DATA_W(DATA_W), .OP_W(OP_W)
) u_chk (.*);

// File: tb/tb_dc_issue_queue.sv
module tb_dc_issue_queue;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 8;
  localparam int NB  = 2;
  localparam int TW  = 6;
  localparam int DW  = 16;
  localparam int OW  = 4;
  localparam int IW  = 3;

  typedef struct packed {
    logic [IW-1:0] slot;
    logic [OW-1:0] op;
    logic [TW-1:0] dst;
    logic [DW-1:0] l;
    logic [DW-1:0] r;
  } exp_t;

  logic clk = 0;
  logic rst_n = 0;
  logic disp_valid = 0, disp_lrdy = 0, disp_rrdy = 0;
  logic [IW-1:0] disp_slot = 0;
  logic [OW-1:0] disp_op = 0;
  logic [TW-1:0] disp_dst = 0, disp_ltag = 0, disp_rtag = 0;
  logic [DW-1:0] disp_lval = 0, disp_rval = 0;
  logic disp_ready;
  logic m0_v = 0, m1_v = 0, a_v = 0;
  logic [TW-1:0] m0_tag = 0, m1_tag = 0, a_tag = 0;
  logic [DW-1:0] m0_val = 0, m1_val = 0, a_val = 0;
  logic [NB-1:0] bc_valid;
  logic [NB*TW-1:0] bc_tag;
  logic [NB*DW-1:0] bc_data;
  logic iss_valid;
  logic iss_ready = 0;
  logic [IW-1:0] iss_slot;
  logic [OW-1:0] iss_op;
  logic [TW-1:0] iss_dst;
  logic [DW-1:0] iss_lval, iss_rval;
  logic free_valid = 0;
  logic [IW-1:0] free_slot = 0;
  logic q_full, q_empty;

  assign bc_valid = {m1_v | a_v, m0_v};
  assign bc_tag   = {(a_v ? a_tag : m1_tag), m0_tag};
  assign bc_data  = {(a_v ? a_val : m1_val), m0_val};

  dc_issue_queue #(.NUM_ENTRIES(N), .NUM_BUS(NB), .TAG_W(TW), .DATA_W(DW), .OP_W(OW)) dut (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_slot(disp_slot),
    .disp_op(disp_op), .disp_dst(disp_dst),
    .disp_ltag(disp_ltag), .disp_lrdy(disp_lrdy), .disp_lval(disp_lval),
    .disp_rtag(disp_rtag), .disp_rrdy(disp_rrdy), .disp_rval(disp_rval),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_slot(iss_slot),
    .iss_op(iss_op), .iss_dst(iss_dst), .iss_lval(iss_lval), .iss_rval(iss_rval),
    .free_valid(free_valid), .free_slot(free_slot),
    .q_full(q_full), .q_empty(q_empty)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int fires  = 0;
  int cyc    = 0;
  bit done   = 0;
  bit auto_exec = 0;
  exp_t  sb[$];
  string sb_req[$];
  logic [TW-1:0] pend_tag[$];
  logic [DW-1:0] pend_val[$];
  int            pend_due[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // scoreboard monitor plus bench execution unit (result broadcast on bus 1)
  always @(negedge clk) begin
    exp_t got, e;
    string rq;
    #1;
    if (rst_n && iss_valid && iss_ready) begin
      fires++;
      got = '{slot: iss_slot, op: iss_op, dst: iss_dst, l: iss_lval, r: iss_rval};
      if (sb.size() == 0) chk(1'b0, "R6 unexpected issue", 64'(got), 64'd0);
      else begin
        e  = sb.pop_front();
        rq = sb_req.pop_front();
        chk(got == e, rq, 64'(got), 64'(e));
      end
      if (auto_exec) begin
        pend_tag.push_back(iss_dst);
        pend_val.push_back(iss_lval + iss_rval);
        pend_due.push_back(cyc + int'($urandom_range(0, 3)));
      end
    end
    a_v = 0;
    if (pend_due.size() > 0 && pend_due[0] <= cyc) begin
      a_v   = 1;
      a_tag = pend_tag.pop_front();
      a_val = pend_val.pop_front();
      void'(pend_due.pop_front());
    end
  end

  task automatic push(input int slot, input int op, input int dst, input int l, input int r, input string req);
    exp_t e;
    e = '{slot: IW'(slot), op: OW'(op), dst: TW'(dst), l: DW'(l), r: DW'(r)};
    sb.push_back(e);
    sb_req.push_back(req);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic dispatch(input int slot, input int op, input int dst,
                          input int lt, input bit lr, input int lv,
                          input int rt, input bit rr, input int rv, output bit acc);
    disp_valid = 1; disp_slot = IW'(slot); disp_op = OW'(op); disp_dst = TW'(dst);
    disp_ltag = TW'(lt); disp_lrdy = lr; disp_lval = DW'(lv);
    disp_rtag = TW'(rt); disp_rrdy = rr; disp_rval = DW'(rv);
    #1 acc = disp_ready;
    @(negedge clk);
    disp_valid = 0;
  endtask

  task automatic bcast0(input int tag, input int val);
    m0_v = 1; m0_tag = TW'(tag); m0_val = DW'(val);
    @(negedge clk);
    m0_v = 0;
  endtask

  task automatic free_one(input int slot);
    free_valid = 1; free_slot = IW'(slot);
    @(negedge clk);
    free_valid = 0;
  endtask

  task automatic wait_fires(input int target, input string req);
    int guard = 0;
    while (fires < target && guard < 300) begin
      @(negedge clk);
      guard++;
    end
    #2;
    chk(fires >= target, req, 64'(fires), 64'(target));
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  localparam int PERM [6] = '{5, 2, 7, 0, 3, 6};

  initial begin
    bit acc;
    int f0;
    logic [DW-1:0] res;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk(q_empty == 1, "R1 q_empty", 64'(q_empty), 64'd1);
    chk(q_full == 0, "R1 q_full", 64'(q_full), 64'd0);
    chk(iss_valid == 0, "R1 iss_valid", 64'(iss_valid), 64'd0);
    chk(disp_ready == 1, "R1 disp_ready", 64'(disp_ready), 64'd1);
    step(1);

    // R3 R12: both operands ready at dispatch
    iss_ready = 1;
    push(3, 5, 10, 16'h1111, 16'h2222, "R3 R12 ready-at-dispatch issue");
    dispatch(3, 5, 10, 1, 1, 16'h1111, 2, 1, 16'h2222, acc);
    chk(acc, "R2 dispatch into free slot", 64'(acc), 64'd1);
    wait_fires(1, "R3 issue count");
    step(3);
    chk(fires == 1, "R6 slot issues once", 64'(fires), 64'd1);

    // R6 R4: waits for left operand, wakes the cycle after broadcast
    dispatch(1, 1, 11, 20, 0, 0, 50, 1, 16'h2222, acc);
    step(2);
    #1 chk(iss_valid == 0, "R6 no bid with missing operand", 64'(iss_valid), 64'd0);
    step(1);
    push(1, 1, 11, 16'hAAAA, 16'h2222, "R4 captured value issued");
    bcast0(20, 16'hAAAA);
    #1 chk(iss_valid == 1 && iss_slot == 1, "R4 offered cycle after broadcast",
           64'({iss_valid, iss_slot}), 64'({1'b1, 3'd1}));
    wait_fires(2, "R4 issue count");

    // R5: ready right operand ignores a later broadcast of its tag
    dispatch(2, 2, 12, 22, 0, 0, 23, 1, 16'h0303, acc);
    bcast0(23, 16'hBEEF);
    #1 chk(iss_valid == 0, "R5 ready operand broadcast does not wake", 64'(iss_valid), 64'd0);
    step(1);
    push(2, 2, 12, 16'h0404, 16'h0303, "R5 value unchanged by late broadcast");
    bcast0(22, 16'h0404);
    wait_fires(3, "R5 issue count");

    // R9: dispatch and matching broadcast in the same cycle
    push(4, 4, 14, 16'h5555, 16'h0006, "R9 same-cycle broadcast captured");
    m0_v = 1; m0_tag = 24; m0_val = 16'h5555;
    dispatch(4, 4, 14, 24, 0, 16'h9999, 51, 1, 16'h0006, acc);
    m0_v = 0;
    #1 chk(iss_valid == 1 && iss_slot == 4, "R9 ready right after dispatch",
           64'({iss_valid, iss_slot}), 64'({1'b1, 3'd4}));
    wait_fires(4, "R9 issue count");

    // R10: two buses carry the same tag, bus 0 wins
    dispatch(5, 6, 15, 25, 0, 0, 52, 1, 16'h0007, acc);
    push(5, 6, 15, 16'h0A0A, 16'h0007, "R10 lowest bus value taken");
    m1_v = 1; m1_tag = 25; m1_val = 16'h0B0B;
    bcast0(25, 16'h0A0A);
    m1_v = 0;
    wait_fires(5, "R10 issue count");

    // R7 R8: two slots wake together under back-pressure
    iss_ready = 0;
    dispatch(7, 7, 17, 27, 0, 0, 53, 1, 16'h0707, acc);
    free_one(2);
    dispatch(2, 2, 12, 27, 0, 0, 54, 1, 16'h0202, acc);
    bcast0(27, 16'h2727);
    #1 chk(iss_valid == 1 && iss_slot == 2, "R7 lowest bidder granted",
           64'({iss_valid, iss_slot}), 64'({1'b1, 3'd2}));
    step(1);
    #1 chk(iss_valid == 1 && iss_slot == 2 && iss_lval == 16'h2727 && iss_rval == 16'h0202,
           "R8 stalled offer held", 64'({iss_valid, iss_slot, iss_lval, iss_rval}),
           64'({1'b1, 3'd2, 16'h2727, 16'h0202}));
    step(1);
    push(2, 2, 12, 16'h2727, 16'h0202, "R7 first of two");
    push(7, 7, 17, 16'h2727, 16'h0707, "R7 second of two");
    iss_ready = 1;
    wait_fires(7, "R7 issue count");

    // R11 R2: empty, fill, refuse, release
    for (int s = 0; s < N; s++) free_one(s);
    #1 chk(q_empty == 1 && q_full == 0, "R11 empty after release",
           64'({q_empty, q_full}), 64'({1'b1, 1'b0}));
    step(1);
    for (int s = 0; s < N; s++) dispatch(s, s, 32 + s, 31, 0, 0, 55, 1, 16 * s + 1, acc);
    #1 chk(q_full == 1 && q_empty == 0, "R11 full after filling",
           64'({q_empty, q_full}), 64'({1'b0, 1'b1}));
    step(1);
    dispatch(3, 15, 63, 1, 1, 16'h7777, 2, 1, 16'h7777, acc);
    chk(acc == 0, "R2 dispatch into occupied slot refused", 64'(acc), 64'd0);
    for (int s = 0; s < N; s++) push(s, s, 32 + s, 16'h3131, 16 * s + 1, "R2 R7 occupant intact, priority order");
    bcast0(31, 16'h3131);
    wait_fires(15, "R2 issue count");
    free_one(3);
    #1 chk(q_full == 0 && q_empty == 0, "R11 not full after one release",
           64'({q_empty, q_full}), 64'({1'b0, 1'b0}));
    step(1);
    for (int s = 0; s < N; s++) free_one(s);

    // R4 R6: dependency chains with randomly delayed result broadcasts
    auto_exec = 1;
    for (int rnd = 0; rnd < 3; rnd++) begin
      f0 = fires;
      res = DW'(16'h0100 * (rnd + 1) + 3);
      push(PERM[0], 8, 40, 16'h0100 * (rnd + 1), 3, "R4 chain head");
      for (int k = 1; k < 6; k++) begin
        push(PERM[k], 8 + k, 40 + k, res, rnd * 16'h0100 + k * 7 + 1, "R4 chain link");
        res = res + DW'(rnd * 16'h0100 + k * 7 + 1);
      end
      for (int k = 5; k >= 1; k--)
        dispatch(PERM[k], 8 + k, 40 + k, 40 + k - 1, 0, 0, 56, 1, rnd * 16'h0100 + k * 7 + 1, acc);
      dispatch(PERM[0], 8, 40, 1, 1, 16'h0100 * (rnd + 1), 2, 1, 3, acc);
      wait_fires(f0 + 6, "R4 chain completes");
      step(6);
      for (int s = 0; s < N; s++) free_one(s);
    end
    auto_exec = 0;
    step(2);
    chk(sb.size() == 0, "R6 all expected issues seen", 64'(sb.size()), 64'd0);
    finish_run();
  end
endmodule